// File: doc/BRIEF.md
# Continuous-Injection Linear Scan Decompressor

This block expands a narrow test-stimulus stream into one bit per internal scan chain on every shift cycle. A 32-bit linear feedback state register advances on each shift. The few scan-in bits of that cycle are XORed into fixed positions of the register as it advances, so the stimulus is a continuous stream and not a single seed. An XOR-only fan-out network then derives each chain's bit from three state bits. Each chain uses its own tap set, so neighbouring chains see decorrelated sequences.

Every output bit in every cycle is a fixed GF(2) linear function of the bits injected since the last initialise. No AND, OR or mux gating sits in the data path. Pattern-generation software can therefore treat each required chain bit as one linear equation in the input stream. A typical pattern drives 4 inputs for about 170 shift cycles into 120 chains. The initialise input clears the state before each pattern, so the response depends only on that pattern's stream.

Top module: `scan_stim_expander`

## Requirements
- R1: While `rst` is high at a rising clock edge, the state and all bits of `chain_out` become 0 at that edge.
- R2: `init` high at an edge clears the state and `chain_out` to 0 at that edge, even when `shift_en` is also high.
- R3: With `shift_en` low (and no `rst` or `init`), the state and `chain_out` keep their values whatever `scan_in` carries.
- R4: On a shift, the state moves up one bit (bit i takes old bit i-1). The new bit 0 is the XOR of old bits 31, 21, 1 and 0, which is the primitive polynomial x^32+x^22+x^2+x+1.
- R5: On the same shift, input bit j is XORed into state bit 8*j after the move, so the 4 inputs land on bits 0, 8, 16 and 24.
- R6: `chain_out` is registered and updates at the same edge as the state. Chain k equals new state bits a^b^c, where g = k/32, a = k mod 32, b = (a+3+2g) mod 32 and c = (a+11+5g) mod 32.
- R7: The path is linear. From a cleared state, the outputs for stream A XOR stream B equal the XOR of the outputs for A and for B, cycle by cycle.
- R8: From a cleared state, an all-zero input stream keeps the state and every chain output at 0.
- R9: Over a full pattern of 170 shift cycles with arbitrary 4-bit inputs, every chain bit in every cycle matches R4 to R6.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Shift clock |
| rst | input | 1 | Synchronous active-high reset |
| init | input | 1 | Synchronous clear of the state before a pattern |
| shift_en | input | 1 | Advances the state and injects `scan_in` when high |
| scan_in | input | 4 | Compressed stimulus bits of this cycle |
| chain_out | output | 120 | One stimulus bit per internal chain |

## Verification
Each of `rst`, `init` and a shift cycle takes effect at the very next rising edge. The new state and the new `chain_out` both appear there, so every result is due one edge after its inputs are driven. The driver applies inputs on the falling edge and queues the expected chain word for that single edge. The monitor takes the word a quarter period after the rising edge, when the register has settled and before the next inputs change. The superposition check for R7 reads outputs at the same point for three streams and compares them cycle by cycle.

// File: rtl/sse_pkg.sv
package sse_pkg;

    // Fibonacci feedback taps of x^32+x^22+x^2+x+1 (state bits 31,21,1,0)
    localparam logic [31:0] FB_MASK_32 = 32'h8020_0003;

    // control decode carried through the state stage
    typedef enum logic [1:0] {
        OP_HOLD  = 2'd0,
        OP_SHIFT = 2'd1,
        OP_CLEAR = 2'd2
    } op_e;

    typedef struct packed {
        op_e  op;
        logic upd_out;
    } ctrl_t;

    // state position that receives input bit j
    function automatic int inj_pos(input int j, input int w, input int n_in);
        return j * (w / n_in);
    endfunction

    // one of the three state taps that feed chain k
    function automatic int ps_tap(input int k, input int idx, input int w);
        int grp;
        int a;
        grp = k / w;
        a   = k % w;
        case (idx)
            0:       return a;
            1:       return (a + 3 + 2 * grp) % w;
            default: return (a + 11 + 5 * grp) % w;
        endcase
    endfunction

    function automatic ctrl_t decode_ctrl(input logic rst, input logic init,
                                          input logic shift_en);
        ctrl_t c;
        if (rst || init) begin
            c.op      = OP_CLEAR;
            c.upd_out = 1'b1;
        end else if (shift_en) begin
            c.op      = OP_SHIFT;
            c.upd_out = 1'b1;
        end else begin
            c.op      = OP_HOLD;
            c.upd_out = 1'b0;
        end
        return c;
    endfunction

endpackage

// File: rtl/sse_ring.sv
module sse_ring #(
    parameter int          W       = 32,
    parameter int          NI      = 4,
    parameter logic [W-1:0] FB     = 32'h8020_0003
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          init,
    input  logic          shift_en,
    input  logic [NI-1:0] scan_in,
    output logic [W-1:0]  state_q,
    output logic [W-1:0]  state_nx
);
    import sse_pkg::*;

    logic [W-1:0] inj_vec;
    logic [W-1:0] moved;
    ctrl_t        ctrl;

    // place each input bit at its own spread-out position
    generate
        for (genvar b = 0; b < W; b++) begin : g_inj
            if ((b % (W / NI)) == 0 && (b / (W / NI)) < NI) begin : g_hit
                assign inj_vec[b] = scan_in[b / (W / NI)];
            end else begin : g_miss
                assign inj_vec[b] = 1'b0;
            end
        end
    endgenerate

    assign moved = {state_q[W-2:0], ^(state_q & FB)};
    assign ctrl  = decode_ctrl(rst, init, shift_en);

    always_comb begin
        case (ctrl.op)
            OP_CLEAR: state_nx = '0;
            OP_SHIFT: state_nx = moved ^ inj_vec;
            default:  state_nx = state_q;
        endcase
    end

    always_ff @(posedge clk) begin
        state_q <= state_nx;
    end

endmodule

// File: rtl/sse_phase_net.sv
module sse_phase_net #(
    parameter int W  = 32,
    parameter int NC = 120
) (
    input  logic [W-1:0]  state_in,
    output logic [NC-1:0] chain_bits
);
    generate
        for (genvar k = 0; k < NC; k++) begin : g_chain
            localparam int TA = sse_pkg::ps_tap(k, 0, W);
            localparam int TB = sse_pkg::ps_tap(k, 1, W);
            localparam int TC = sse_pkg::ps_tap(k, 2, W);
            assign chain_bits[k] = state_in[TA] ^ state_in[TB] ^ state_in[TC];
        end
    endgenerate
endmodule

// File: rtl/scan_stim_expander.sv
module scan_stim_expander #(
    parameter int N_IN    = 4,
    parameter int N_CHAIN = 120,
    parameter int STATE_W = 32
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               init,
    input  logic               shift_en,
    input  logic [N_IN-1:0]    scan_in,
    output logic [N_CHAIN-1:0] chain_out
);
    import sse_pkg::*;

    localparam logic [STATE_W-1:0] FB = STATE_W'(FB_MASK_32);

    logic [STATE_W-1:0] state_q;
    logic [STATE_W-1:0] state_nx;
    logic [N_CHAIN-1:0] chain_nx;
    ctrl_t              ctrl;

    sse_ring #(.W(STATE_W), .NI(N_IN), .FB(FB)) u_ring (
        .clk      (clk),
        .rst      (rst),
        .init     (init),
        .shift_en (shift_en),
        .scan_in  (scan_in),
        .state_q  (state_q),
        .state_nx (state_nx)
    );

    sse_phase_net #(.W(STATE_W), .NC(N_CHAIN)) u_phase (
        .state_in   (state_nx),
        .chain_bits (chain_nx)
    );

    assign ctrl = decode_ctrl(rst, init, shift_en);

    always_ff @(posedge clk) begin
        if (ctrl.upd_out) begin
            chain_out <= chain_nx;
        end
    end

endmodule

// File: rtl/sse_chk.sv
module sse_chk #(
    parameter int W  = 32,
    parameter int NI = 4,
    parameter int NC = 120
) (
    input logic          clk,
    input logic          rst,
    input logic          init,
    input logic          shift_en,
    input logic [NI-1:0] scan_in,
    input logic [W-1:0]  state,
    input logic [NC-1:0] chain_out
);
    // R2
    a_r2_init_clears: assert property (@(posedge clk) disable iff (rst)
        init |=> (state == '0) && (chain_out == '0));

    // R3
    a_r3_hold: assert property (@(posedge clk) disable iff (rst)
        (!init && !shift_en) |=> $stable(state) && $stable(chain_out));

    // R4
    a_r4_moves_up: assert property (@(posedge clk) disable iff (rst)
        (!init && shift_en && scan_in == '0) |=> state[W-1:1] == $past(state[W-2:0]));

    // R5
    a_r5_single_inject: assert property (@(posedge clk) disable iff (rst)
        (!init && shift_en && state == '0 && $countones(scan_in) == 1)
        |=> $countones(state) == 1);

    // R8
    a_r8_zero_stays: assert property (@(posedge clk) disable iff (rst)
        (!init && shift_en && state == '0 && scan_in == '0)
        |=> (state == '0) && (chain_out == '0));
endmodule

bind scan_stim_expander sse_chk #(.W(STATE_W), .NI(N_IN), .NC(N_CHAIN)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .init      (init),
    .shift_en  (shift_en),
    .scan_in   (scan_in),
    .state     (state_q),
    .chain_out (chain_out)
);

// File: tb/test_scan_stim_expander.sv
module test_scan_stim_expander;
    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         init = 1'b0;
    logic         shift_en = 1'b0;
    logic [3:0]   scan_in = '0;
    logic [119:0] chain_out;

    typedef struct {
        logic [119:0] exp;
        string        tag;
    } item_t;

    item_t        sb_q[$];
    int           n_run = 0;
    int           n_fail = 0;
    logic [31:0]  m_st = '0;
    logic [119:0] seen;
    logic [119:0] out_a[12];
    logic [119:0] out_b[12];
    logic [3:0]   str_a[12];
    logic [3:0]   str_b[12];

    always #10 clk = ~clk;

    scan_stim_expander i_scan_stim_expander (
        .clk(clk), .rst(rst), .init(init), .shift_en(shift_en),
        .scan_in(scan_in), .chain_out(chain_out)
    );

    function automatic logic [119:0] expand(input logic [31:0] s);
        logic [119:0] r;
        for (int k = 0; k < 120; k++) begin
            int g = k / 32;
            int a = k % 32;
            r[k] = s[a] ^ s[(a + 3 + 2 * g) % 32] ^ s[(a + 11 + 5 * g) % 32];
        end
        return r;
    endfunction

    task automatic drive(input logic r, input logic ini, input logic sh,
                         input logic [3:0] din, input string tag);
        @(negedge clk);
        rst = r; init = ini; shift_en = sh; scan_in = din;
        if (r || ini) m_st = '0;
        else if (sh) begin
            logic fb;
            fb   = m_st[31] ^ m_st[21] ^ m_st[1] ^ m_st[0];
            m_st = {m_st[30:0], fb};
            m_st[0]  ^= din[0];
            m_st[8]  ^= din[1];
            m_st[16] ^= din[2];
            m_st[24] ^= din[3];
        end
        sb_q.push_back('{exp: expand(m_st), tag: tag});
    endtask

    always @(posedge clk) begin
        #5;
        seen = chain_out;
        if (sb_q.size() > 0) begin
            item_t it;
            it = sb_q.pop_front();
            n_run++;
            if (chain_out !== it.exp) begin
                n_fail++;
                $display("FAIL %s: got %h expected %h", it.tag, chain_out, it.exp);
            end
        end
    end

    task automatic own_check(input bit ok, input string tag,
                             input logic [119:0] act, input logic [119:0] exp);
        n_run++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: got %h expected %h", tag, act, exp);
        end
    endtask

    initial begin
        #(20 * 100000);
        n_fail++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        // R1: reset state
        for (int i = 0; i < 3; i++) drive(1, 0, 0, 4'hF, "R1 reset");
        drive(0, 1, 0, 0, "R2 init");

        // R5 / R4 / R6: one input bit at a time, then let it walk
        for (int j = 0; j < 4; j++) begin
            drive(0, 1, 0, 0, "R2 init");
            drive(0, 0, 1, 4'(1 << j), "R5 inject position");
            for (int c = 0; c < 40; c++) drive(0, 0, 1, 0, "R4 R6 recurrence");
        end

        // R3: hold with noise on scan_in
        drive(0, 0, 1, 4'hA, "R6 shift");
        for (int c = 0; c < 6; c++) drive(0, 0, 0, 4'(c * 5 + 3), "R3 hold");
        drive(0, 0, 1, 4'h3, "R6 shift after hold");

        // R2: init during shift wins
        drive(0, 1, 1, 4'hF, "R2 init over shift");

        // R8: zero stream stays zero
        for (int c = 0; c < 20; c++) drive(0, 0, 1, 0, "R8 zero stream");

        // R9: full pattern
        drive(0, 1, 0, 0, "R2 init");
        for (int c = 0; c < 170; c++) drive(0, 0, 1, 4'($urandom), "R9 pattern");

        // R7: superposition
        for (int c = 0; c < 12; c++) begin
            str_a[c] = 4'($urandom);
            str_b[c] = 4'($urandom);
        end
        drive(0, 1, 0, 0, "R2 init");
        for (int c = 0; c < 12; c++) begin
            drive(0, 0, 1, str_a[c], "R7 stream A");
            @(posedge clk); #6; out_a[c] = seen;
        end
        drive(0, 1, 0, 0, "R2 init");
        for (int c = 0; c < 12; c++) begin
            drive(0, 0, 1, str_b[c], "R7 stream B");
            @(posedge clk); #6; out_b[c] = seen;
        end
        drive(0, 1, 0, 0, "R2 init");
        for (int c = 0; c < 12; c++) begin
            drive(0, 0, 1, str_a[c] ^ str_b[c], "R7 stream A^B");
            @(posedge clk); #6;
            own_check(seen === (out_a[c] ^ out_b[c]), "R7 superposition",
                      seen, out_a[c] ^ out_b[c]);
        end

        // R1 again after activity
        drive(1, 0, 1, 4'hF, "R1 reset after use");
        drive(0, 0, 0, 0, "R3 hold after reset");

        while (sb_q.size() > 0) @(posedge clk);
        @(negedge clk);
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule